// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides whether one more thread block may become resident on a single multiprocessor. It keeps four running totals: thread contexts, registers, shared-memory bytes and the number of resident blocks. A new block is let in only when every one of the four totals can take its whole demand. Whichever total runs out first sets how many blocks can be resident. A block is never split or partly granted.

A request carries its thread count, registers per thread and shared bytes per block. It is offered with a valid signal and accepted when ready is high. A request that does not fit keeps ready low and waits at the head of the queue. A request that asks for more threads than one block may hold is consumed at once and flagged as rejected.

Finishing blocks hand their resources back on a release port. That port uses the same three fields as the request. A combinational headroom output tells how many more blocks shaped like the current request fields would still fit.

Top module: `sm_block_gate`

## Requirements
- R1: After reset all four totals are zero. The error output is 0. A 256-thread request with no registers and no shared memory is ready, and the headroom output for it is 3.
- R2: Thread contexts are charged in whole 32-thread warps. After a 500-thread block is admitted, a 256-thread block still fits, and a further 1-thread request does not.
- R3: No more than 768 thread contexts are resident. Three 256-thread blocks are admitted, and a fourth request of 32 threads waits.
- R4: No more than 8 blocks are resident, however small they are. A ninth 32-thread block waits.
- R5: A block uses threads × registers-per-thread of an 8192-entry register pool. Two blocks of 256 threads × 16 registers fill the pool, and a 32-thread × 1-register block then waits.
- R6: Shared memory is a 16384-byte pool. Two 6000-byte blocks fit, and a third 6000-byte block waits.
- R7: A request for more than 512 threads is accepted with ready high and req_reject high in the same cycle. It changes no total.
- R8: A request that does not fit holds ready low for as long as it stays unserved. It is never partly granted.
- R9: A release and a request in the same cycle are both applied, with the release counted first. A request that fits only because of that release is ready in that cycle.
- R10: The headroom output is the smallest, across the four pools, of the space left divided by the per-block need. A pool with zero need sets no limit.
- R11: A release larger than what is held clamps that total at zero. It also sets err_release, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block request is offered |
| req_ready | output | 1 | The offered request is accepted (it fits, or it is oversized) |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 8 | Registers per thread of the requested block |
| req_smem | input | 15 | Shared bytes of the requested block |
| req_reject | output | 1 | The offered request is oversized and is dropped |
| rel_valid | input | 1 | A resident block finishes and returns its resources |
| rel_threads | input | 10 | Threads of the finishing block |
| rel_regs | input | 8 | Registers per thread of the finishing block |
| rel_smem | input | 15 | Shared bytes of the finishing block |
| spare_blocks | output | 4 | How many more blocks shaped like the request fields would fit |
| err_release | output | 1 | Sticky flag: a release exceeded what was held |

## Verification
The hardest case to reach from the ports is a waiting request that becomes ready only because a release lands in the same cycle. The stimulus first fills the thread pool exactly with a 512-thread block and a 256-thread block. It then holds a 256-thread request unserved for several cycles. Finally it raises the release of the 256-thread block on the very cycle the request is still offered, and checks that ready rises in that cycle and not one cycle later. Warp rounding is exposed with a 500-thread block. Without rounding, that block would leave room for a 1-thread block.

// File: rtl/blkgate_pkg.sv
package blkgate_pkg;
  localparam int AW = 32;

  // thread contexts charged in whole warps
  function automatic logic [AW-1:0] warp_round(input logic [AW-1:0] t, input int unsigned w);
    logic [AW-1:0] ww;
    ww = AW'(w);
    return ((t + ww - 1) / ww) * ww;
  endfunction

  // register demand of a block
  function automatic logic [AW-1:0] reg_need(input logic [AW-1:0] t, input logic [AW-1:0] r);
    return t * r;
  endfunction

  // blocks of size n that fit into a, zero need sets no limit
  function automatic logic [AW-1:0] quot(input logic [AW-1:0] a, input logic [AW-1:0] n,
                                         input int unsigned lim);
    return (n == '0) ? AW'(lim) : a / n;
  endfunction
endpackage

// File: rtl/bg_pool.sv
module bg_pool
  import blkgate_pkg::*;
#(
  parameter int unsigned CAP = 768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel_en,
  input  logic [AW-1:0] rel_amt,
  input  logic          add_en,
  input  logic [AW-1:0] add_amt,
  output logic [AW-1:0] avail,
  output logic          fits,
  output logic          rel_over
);
  localparam int W = $clog2(CAP + 1);

  logic [W-1:0]  used_q;
  logic [AW-1:0] used_w;
  logic [AW-1:0] after_rel;
  logic [AW-1:0] next_w;

  assign used_w    = AW'(used_q);
  assign rel_over  = rel_en && (rel_amt > used_w);
  assign after_rel = !rel_en ? used_w : (rel_over ? '0 : used_w - rel_amt);
  assign avail     = AW'(CAP) - after_rel;
  assign fits      = add_amt <= avail;
  assign next_w    = after_rel + (add_en ? add_amt : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= W'(next_w);
  end

  // Pool never holds more than its capacity (R3; same for R4, R5 and R6 per instance)
  p_pool_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used_w <= AW'(CAP));

  // An over-release leaves the pool empty
  p_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_over && !add_en) |=> (used_q == '0));
endmodule

// File: rtl/bg_headroom.sv
module bg_headroom
  import blkgate_pkg::*;
#(
  parameter int unsigned MAXB = 8,
  parameter int          NP   = 4,
  localparam int         SPW  = $clog2(MAXB + 1)
) (
  input  logic [AW-1:0]  avail [NP],
  input  logic [AW-1:0]  need  [NP],
  output logic [SPW-1:0] spare
);
  logic [AW-1:0] m;

  always_comb begin
    m = AW'(MAXB);
    for (int i = 0; i < NP; i++) begin
      if (quot(avail[i], need[i], MAXB) < m) m = quot(avail[i], need[i], MAXB);
    end
    spare = SPW'(m);
  end
endmodule

// File: rtl/sm_block_gate.sv
module sm_block_gate
  import blkgate_pkg::*;
#(
  parameter int unsigned N_THREADS  = 768,
  parameter int unsigned N_REGS     = 8192,
  parameter int unsigned N_SMEM     = 16384,
  parameter int unsigned N_BLOCKS   = 8,
  parameter int unsigned BLK_THR_MX = 512,
  parameter int unsigned WARP       = 32,
  parameter int          TW         = 10,
  parameter int          RW         = 8,
  parameter int          SW         = 15,
  localparam int         SPW        = $clog2(N_BLOCKS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [TW-1:0]  req_threads,
  input  logic [RW-1:0]  req_regs,
  input  logic [SW-1:0]  req_smem,
  output logic           req_reject,
  input  logic           rel_valid,
  input  logic [TW-1:0]  rel_threads,
  input  logic [RW-1:0]  rel_regs,
  input  logic [SW-1:0]  rel_smem,
  output logic [SPW-1:0] spare_blocks,
  output logic           err_release
);
  localparam int NP = 4;
  localparam int unsigned CAPS [NP] = '{N_THREADS, N_REGS, N_SMEM, N_BLOCKS};

  logic [AW-1:0] q_need [NP];
  logic [AW-1:0] r_need [NP];
  logic [AW-1:0] avail  [NP];
  logic [NP-1:0] fits;
  logic [NP-1:0] over;
  logic          oversize;
  logic          admit;
  logic          err_q;

  assign q_need[0] = warp_round(AW'(req_threads), WARP);
  assign q_need[1] = reg_need(AW'(req_threads), AW'(req_regs));
  assign q_need[2] = AW'(req_smem);
  assign q_need[3] = AW'(1);
  assign r_need[0] = warp_round(AW'(rel_threads), WARP);
  assign r_need[1] = reg_need(AW'(rel_threads), AW'(rel_regs));
  assign r_need[2] = AW'(rel_smem);
  assign r_need[3] = AW'(1);

  assign oversize   = AW'(req_threads) > AW'(BLK_THR_MX);
  assign admit      = req_valid && !oversize && (&fits);
  assign req_ready  = oversize || (&fits);
  assign req_reject = req_valid && oversize;

  for (genvar g = 0; g < NP; g++) begin : g_pool
    bg_pool #(.CAP(CAPS[g])) u_pool (
      .clk     (clk),
      .rst_n   (rst_n),
      .rel_en  (rel_valid),
      .rel_amt (r_need[g]),
      .add_en  (admit),
      .add_amt (q_need[g]),
      .avail   (avail[g]),
      .fits    (fits[g]),
      .rel_over(over[g])
    );
  end

  bg_headroom #(.MAXB(N_BLOCKS), .NP(NP)) u_head (
    .avail(avail),
    .need (q_need),
    .spare(spare_blocks)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|over);
  end
  assign err_release = err_q;

  // Oversized requests are consumed, never left waiting
  p_reject_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> req_ready);

  // Accepted legal request implies the headroom saw room for it
  p_admit_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_reject) |-> (spare_blocks != '0));

  // Headroom and ready agree for legal requests
  p_room_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oversize && spare_blocks != '0) |-> req_ready);

  // Error flag is sticky
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_release |=> err_release);
endmodule

// File: tb/sm_block_gate_bench.sv
module sm_block_gate_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [9:0] req_threads = '0;
  logic [7:0] req_regs = '0;
  logic [14:0] req_smem = '0;
  logic       req_reject;
  logic       rel_valid = 1'b0;
  logic [9:0] rel_threads = '0;
  logic [7:0] rel_regs = '0;
  logic [14:0] rel_smem = '0;
  logic [3:0] spare_blocks;
  logic       err_release;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sm_block_gate u_sm_block_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs), .req_smem(req_smem),
    .req_reject(req_reject),
    .rel_valid(rel_valid), .rel_threads(rel_threads), .rel_regs(rel_regs),
    .rel_smem(rel_smem),
    .spare_blocks(spare_blocks), .err_release(err_release)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic admit(input int t, input int r, input int s, input bit exp, input string tag);
    @(negedge clk);
    req_threads = 10'(t); req_regs = 8'(r); req_smem = 15'(s); req_valid = 1'b1;
    #1 chk(req_ready == exp, tag, int'(req_ready), int'(exp));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic release_blk(input int t, input int r, input int s);
    @(negedge clk);
    rel_threads = 10'(t); rel_regs = 8'(r); rel_smem = 15'(s); rel_valid = 1'b1;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic query(input int t, input int r, input int s, input int exp, input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    req_threads = 10'(t); req_regs = 8'(r); req_smem = 15'(s);
    #1 chk(int'(spare_blocks) == exp, tag, int'(spare_blocks), exp);
  endtask

  task automatic t_reset();
    query(256, 0, 0, 3, "R1 headroom");
    chk(err_release == 1'b0, "R1 err", int'(err_release), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_threads();
    for (int i = 0; i < 3; i++) admit(256, 0, 0, 1'b1, "R3 admit");
    admit(32, 0, 0, 1'b0, "R3 full");
    query(32, 0, 0, 0, "R3 headroom");
    for (int i = 0; i < 3; i++) release_blk(256, 0, 0);
    query(256, 0, 0, 3, "R3 freed");
  endtask

  task automatic t_warp();
    admit(500, 0, 0, 1'b1, "R2 first");
    admit(256, 0, 0, 1'b1, "R2 second");
    admit(1, 0, 0, 1'b0, "R2 rounded out");
    release_blk(500, 0, 0);
    release_blk(256, 0, 0);
    query(256, 0, 0, 3, "R2 freed");
    chk(err_release == 1'b0, "R2 no err", int'(err_release), 0);
  endtask

  task automatic t_blocks();
    for (int i = 0; i < 8; i++) admit(32, 0, 0, 1'b1, "R4 admit");
    admit(32, 0, 0, 1'b0, "R4 ninth");
    query(32, 0, 0, 0, "R4 headroom");
    for (int i = 0; i < 8; i++) release_blk(32, 0, 0);
    query(32, 0, 0, 8, "R4 freed");
  endtask

  task automatic t_regs();
    query(256, 16, 0, 2, "R5 headroom");
    admit(256, 16, 0, 1'b1, "R5 a");
    admit(256, 16, 0, 1'b1, "R5 b");
    admit(32, 1, 0, 1'b0, "R5 full");
    release_blk(256, 16, 0);
    release_blk(256, 16, 0);
    query(256, 16, 0, 2, "R5 freed");
  endtask

  task automatic t_smem();
    admit(32, 0, 6000, 1'b1, "R6 a");
    admit(32, 0, 6000, 1'b1, "R6 b");
    admit(32, 0, 6000, 1'b0, "R6 full");
    query(32, 0, 4000, 1, "R10 smem headroom");
    release_blk(32, 0, 6000);
    release_blk(32, 0, 6000);
    query(32, 0, 6000, 2, "R10 freed smem");
  endtask

  task automatic t_reject();
    @(negedge clk);
    req_threads = 10'd600; req_regs = '0; req_smem = '0; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R7 ready", int'(req_ready), 1);
    chk(req_reject == 1'b1, "R7 reject", int'(req_reject), 1);
    @(negedge clk);
    req_valid = 1'b0;
    query(256, 0, 0, 3, "R7 unchanged");
  endtask

  task automatic t_wait_same_cycle();
    admit(512, 0, 0, 1'b1, "R8 fill a");
    admit(256, 0, 0, 1'b1, "R8 fill b");
    @(negedge clk);
    req_threads = 10'd256; req_regs = '0; req_smem = '0; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 chk(req_ready == 1'b0, "R8 held", int'(req_ready), 0);
      @(negedge clk);
    end
    rel_threads = 10'd256; rel_regs = '0; rel_smem = '0; rel_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R9 same cycle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0;
    query(32, 0, 0, 0, "R9 refilled");
    release_blk(512, 0, 0);
    release_blk(256, 0, 0);
    query(256, 0, 0, 3, "R9 freed");
  endtask

  task automatic t_over_release();
    release_blk(32, 0, 0);
    #1 chk(err_release == 1'b1, "R11 err", int'(err_release), 1);
    query(256, 0, 0, 3, "R11 clamp");
    @(negedge clk);
    chk(err_release == 1'b1, "R11 sticky", int'(err_release), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_threads();
    t_warp();
    t_blocks();
    t_regs();
    t_smem();
    t_reject();
    t_wait_same_cycle();
    t_over_release();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule